// File: doc/BRIEF.md
# Access Violation Fault Recorder

This block sits beside a memory-protection filter bank and keeps a record of denied transactions. Each filter that turns an access away sends a one-cycle deny pulse. The pulse carries the filter index, the full address, whether the access was a read or a write, whether it was secure or non-secure, whether it was privileged, the master ID and the virtual network number. The recorder keeps the first such fault for each filter until software clears it. It also flags any further fault that arrives before the clear, and can raise an interrupt line.

Software reaches the recorder through a simple word-addressed register port. Writes take effect on the clock edge, and reads are combinational from the stored state. Through this port it programs the action setting, reads the status word, acknowledges faults through a write-only clear word, and reads each filter's record: address low and high words, control word and ID word. A separate per-filter overlap pulse input, from the region match logic, sets sticky overlap flags in the same status word.

Top module: `fault_recorder`

## Requirements
- R1: After reset, the status word, every fault record and the action setting read as zero, and irq_o is low.
- R2: A deny pulse for filter f whose violation flag is clear has these effects after the next clock edge. Status bit f is set. The address low word holds address bits 31:0. The address high word holds the remaining upper address bits, zero-extended.
- R3: In the control word, bit 24 holds the direction (1 = write, 0 = read). Bit 21 holds security (1 = non-secure, 0 = secure). Bit 20 holds privilege (1 = unprivileged, 0 = privileged). All other bits are zero.
- R4: The ID word carries the virtual network number in bits 27:24 and the master ID zero-extended in its low bits.
- R5: A deny pulse for filter f while status bit f is still set sets the overrun flag at status bit 8+f and leaves that filter's record unchanged.
- R6: A pulse on overlap_i bit f sets the sticky overlap flag at status bit 16+f.
- R7: Writing the clear word (offset 0x08) with bit f of the data set clears filter f's violation, overrun and overlap flags. Filters whose clear bit is zero keep their flags.
- R8: A deny for filter f in the same cycle as a clear of filter f leaves the violation flag set. It replaces the record with the new fault and does not set the overrun flag.
- R9: irq_o is high exactly when action bit 1 is set and at least one violation flag is set. Action bit 0 alone never raises it.
- R10: A fault on one filter never changes another filter's record.
- R11: The register map is as follows. Action is at 0x00, bits 1:0, read/write. Status is at 0x04, read-only. Clear is at 0x08 and reads as zero. The record for filter f starts at 0x20+0x10*f, with address low at +0x0, address high at +0x4, control at +0x8 and ID at +0xC. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| deny_valid_i | input | 1 | One-cycle pulse: an access was denied |
| deny_filt_i | input | FW | Index of the denying filter |
| deny_addr_i | input | ADDR_W | Address of the denied access |
| deny_write_i | input | 1 | 1 = write, 0 = read |
| deny_nonsec_i | input | 1 | 1 = non-secure access |
| deny_unpriv_i | input | 1 | 1 = unprivileged access |
| deny_id_i | input | ID_W | Master ID |
| deny_vnet_i | input | VNET_W | Virtual network number |
| overlap_i | input | NF | Per-filter region overlap pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Violation interrupt |

## Verification
Deny pulses, overlap pulses and register writes are applied on the falling edge. All of them land in state at the next rising edge, so their effect on any read word or on irq_o is due one cycle later. Register reads are combinational, so the bench sets the offset on a falling edge and samples a moment later, always after the edge that committed the preceding stimulus. irq_o follows the stored flags and action with no extra register, so it is also due one edge after the write or pulse that changes them.

// File: rtl/fault_rec_pkg.sv
package fault_rec_pkg;
  localparam logic [7:0] OFF_ACTION   = 8'h00;
  localparam logic [7:0] OFF_STATUS   = 8'h04;
  localparam logic [7:0] OFF_CLEAR    = 8'h08;
  localparam logic [7:0] OFF_REC_BASE = 8'h20;
  localparam int unsigned REC_STRIDE  = 16;

  localparam int unsigned STAT_OVR_LSB = 8;
  localparam int unsigned STAT_OVL_LSB = 16;
  localparam int unsigned CTL_WR_BIT   = 24;
  localparam int unsigned CTL_NS_BIT   = 21;
  localparam int unsigned CTL_UP_BIT   = 20;
  localparam int unsigned ID_VNET_LSB  = 24;

  typedef struct packed {
    logic write;
    logic nonsec;
    logic unpriv;
  } acc_attr_t;
endpackage

// File: rtl/fault_slot.sv
module fault_slot
  import fault_rec_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned ID_W   = 8,
  parameter int unsigned VNET_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic              clr_i,
  input  logic              ovl_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  acc_attr_t         attr_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [VNET_W-1:0] vnet_i,
  output logic              flag_o,
  output logic              ovr_o,
  output logic              ovl_o,
  output logic [ADDR_W-1:0] addr_o,
  output acc_attr_t         attr_o,
  output logic [ID_W-1:0]   id_o,
  output logic [VNET_W-1:0] vnet_o
);
  logic capture;
  // a clear in the same cycle frees the slot for the incoming fault
  assign capture = hit_i && (!flag_o || clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      ovr_o  <= 1'b0;
      ovl_o  <= 1'b0;
    end else begin
      flag_o <= (flag_o && !clr_i) || hit_i;
      ovr_o  <= (ovr_o && !clr_i) || (hit_i && flag_o && !clr_i);
      ovl_o  <= (ovl_o && !clr_i) || ovl_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      attr_o <= '0;
      id_o   <= '0;
      vnet_o <= '0;
    end else if (capture) begin
      addr_o <= addr_i;
      attr_o <= attr_i;
      id_o   <= id_i;
      vnet_o <= vnet_i;
    end
  end
endmodule

// File: rtl/fault_rdmux.sv
module fault_rdmux
  import fault_rec_pkg::*;
#(
  parameter int unsigned NF     = 4,
  parameter int unsigned FW     = 2,
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned ID_W   = 8,
  parameter int unsigned VNET_W = 4
) (
  input  logic [7:0]                  addr_i,
  input  logic [1:0]                  act_i,
  input  logic [NF-1:0]               flag_i,
  input  logic [NF-1:0]               ovr_i,
  input  logic [NF-1:0]               ovl_i,
  input  logic [NF-1:0][ADDR_W-1:0]   rec_addr_i,
  input  acc_attr_t [NF-1:0]          rec_attr_i,
  input  logic [NF-1:0][ID_W-1:0]     rec_id_i,
  input  logic [NF-1:0][VNET_W-1:0]   rec_vnet_i,
  output logic [31:0]                 rdata_o
);
  localparam logic [7:0] REC_SPAN = 8'(REC_STRIDE * NF);

  logic [7:0]    rel;
  logic          in_rec;
  logic [FW-1:0] idx;
  logic [1:0]    word;
  logic [63:0]   full_addr;
  logic [31:0]   status;
  logic          unused_rd;

  assign rel       = addr_i - OFF_REC_BASE;
  assign in_rec    = (addr_i >= OFF_REC_BASE) && (rel < REC_SPAN);
  assign idx       = rel[FW+3:4];
  assign word      = rel[3:2];
  assign full_addr = 64'(rec_addr_i[idx]);
  assign unused_rd = ^rel;

  always_comb begin
    status = '0;
    status[NF-1:0]                       = flag_i;
    status[STAT_OVR_LSB +: NF]           = ovr_i;
    status[STAT_OVL_LSB +: NF]           = ovl_i;
  end

  always_comb begin
    rdata_o = '0;
    if (in_rec) begin
      case (word)
        2'd0: rdata_o = full_addr[31:0];
        2'd1: rdata_o = full_addr[63:32];
        2'd2: begin
          rdata_o[CTL_WR_BIT] = rec_attr_i[idx].write;
          rdata_o[CTL_NS_BIT] = rec_attr_i[idx].nonsec;
          rdata_o[CTL_UP_BIT] = rec_attr_i[idx].unpriv;
        end
        default: begin
          rdata_o[ID_W-1:0]                = rec_id_i[idx];
          rdata_o[ID_VNET_LSB +: VNET_W]   = rec_vnet_i[idx];
        end
      endcase
    end else begin
      case (addr_i)
        OFF_ACTION: rdata_o = 32'(act_i);
        OFF_STATUS: rdata_o = status;
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/fault_recorder.sv
module fault_recorder
  import fault_rec_pkg::*;
#(
  parameter int unsigned NF     = 4,
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned ID_W   = 8,
  parameter int unsigned VNET_W = 4,
  localparam int unsigned FW    = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              deny_valid_i,
  input  logic [FW-1:0]     deny_filt_i,
  input  logic [ADDR_W-1:0] deny_addr_i,
  input  logic              deny_write_i,
  input  logic              deny_nonsec_i,
  input  logic              deny_unpriv_i,
  input  logic [ID_W-1:0]   deny_id_i,
  input  logic [VNET_W-1:0] deny_vnet_i,
  input  logic [NF-1:0]     overlap_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  logic [1:0]                act_q;
  logic [NF-1:0]             flag_v, ovr_v, ovl_v;
  logic [NF-1:0][ADDR_W-1:0] rec_addr;
  acc_attr_t [NF-1:0]        rec_attr;
  logic [NF-1:0][ID_W-1:0]   rec_id;
  logic [NF-1:0][VNET_W-1:0] rec_vnet;
  acc_attr_t                 in_attr;
  logic                      clr_we;
  logic                      unused_wd;

  assign in_attr   = '{write: deny_write_i, nonsec: deny_nonsec_i, unpriv: deny_unpriv_i};
  assign clr_we    = reg_we_i && (reg_addr_i == OFF_CLEAR);
  assign unused_wd = ^reg_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    act_q <= '0;
    else if (reg_we_i && reg_addr_i == OFF_ACTION)  act_q <= reg_wdata_i[1:0];
  end

  for (genvar f = 0; f < NF; f++) begin : g_slot
    fault_slot #(.ADDR_W(ADDR_W), .ID_W(ID_W), .VNET_W(VNET_W)) slot_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hit_i  (deny_valid_i && (deny_filt_i == FW'(f))),
      .clr_i  (clr_we && reg_wdata_i[f]),
      .ovl_i  (overlap_i[f]),
      .addr_i (deny_addr_i),
      .attr_i (in_attr),
      .id_i   (deny_id_i),
      .vnet_i (deny_vnet_i),
      .flag_o (flag_v[f]),
      .ovr_o  (ovr_v[f]),
      .ovl_o  (ovl_v[f]),
      .addr_o (rec_addr[f]),
      .attr_o (rec_attr[f]),
      .id_o   (rec_id[f]),
      .vnet_o (rec_vnet[f])
    );
  end

  fault_rdmux #(.NF(NF), .FW(FW), .ADDR_W(ADDR_W), .ID_W(ID_W), .VNET_W(VNET_W)) rdmux_i (
    .addr_i     (reg_addr_i),
    .act_i      (act_q),
    .flag_i     (flag_v),
    .ovr_i      (ovr_v),
    .ovl_i      (ovl_v),
    .rec_addr_i (rec_addr),
    .rec_attr_i (rec_attr),
    .rec_id_i   (rec_id),
    .rec_vnet_i (rec_vnet),
    .rdata_o    (reg_rdata_o)
  );

  assign irq_o = act_q[1] && (|flag_v);
endmodule

// File: rtl/fault_recorder_chk.sv
module fault_recorder_chk
  import fault_rec_pkg::*;
#(
  parameter int unsigned NF     = 4,
  parameter int unsigned FW     = 2,
  parameter int unsigned ADDR_W = 48
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      deny_valid_i,
  input logic [FW-1:0]             deny_filt_i,
  input logic                      reg_we_i,
  input logic [7:0]                reg_addr_i,
  input logic [31:0]               reg_wdata_i,
  input logic [1:0]                act_q,
  input logic [NF-1:0]             flag_v,
  input logic [NF-1:0]             ovr_v,
  input logic [NF-1:0][ADDR_W-1:0] rec_addr,
  input logic                      irq_o
);
  logic hit_ok;
  assign hit_ok = deny_valid_i && (32'(deny_filt_i) < NF);

  p_flag_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_ok |=> flag_v[$past(deny_filt_i)]);

  p_overrun_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_ok && flag_v[deny_filt_i] && !reg_we_i) |=> ovr_v[$past(deny_filt_i)]);

  p_record_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_ok && flag_v[deny_filt_i] && !reg_we_i) |=> $stable(rec_addr));

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFF_CLEAR && !deny_valid_i)
      |=> ((flag_v & $past(reg_wdata_i[NF-1:0])) == '0));

  p_irq_raise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_ok && act_q[1] && !reg_we_i) |=> irq_o);

  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_q[1] && !reg_we_i) |=> !irq_o);
endmodule

bind fault_recorder fault_recorder_chk #(.NF(NF), .FW(FW), .ADDR_W(ADDR_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .deny_valid_i (deny_valid_i),
  .deny_filt_i  (deny_filt_i),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .act_q        (act_q),
  .flag_v       (flag_v),
  .ovr_v        (ovr_v),
  .rec_addr     (rec_addr),
  .irq_o        (irq_o)
);

// File: tb/fault_recorder_tb_top.sv
module fault_recorder_tb_top;
  localparam int NF = 4, FW = 2, AW = 48, IW = 8, VW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          deny_valid = 1'b0;
  logic [FW-1:0] deny_filt = '0;
  logic [AW-1:0] deny_addr = '0;
  logic          deny_write = 1'b0, deny_nonsec = 1'b0, deny_unpriv = 1'b0;
  logic [IW-1:0] deny_id = '0;
  logic [VW-1:0] deny_vnet = '0;
  logic [NF-1:0] overlap = '0;
  logic          reg_we = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  fault_recorder #(.NF(NF), .ADDR_W(AW), .ID_W(IW), .VNET_W(VW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .deny_valid_i(deny_valid), .deny_filt_i(deny_filt), .deny_addr_i(deny_addr),
    .deny_write_i(deny_write), .deny_nonsec_i(deny_nonsec), .deny_unpriv_i(deny_unpriv),
    .deny_id_i(deny_id), .deny_vnet_i(deny_vnet), .overlap_i(overlap),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic set_deny(input int f, input logic [AW-1:0] a, input logic w, input logic ns,
                          input logic up, input logic [IW-1:0] id, input logic [VW-1:0] vn);
    deny_valid = 1'b1; deny_filt = FW'(f); deny_addr = a;
    deny_write = w; deny_nonsec = ns; deny_unpriv = up; deny_id = id; deny_vnet = vn;
  endtask

  task automatic deny(input int f, input logic [AW-1:0] a, input logic w, input logic ns,
                      input logic up, input logic [IW-1:0] id, input logic [VW-1:0] vn);
    @(negedge clk);
    set_deny(f, a, w, ns, up, id, vn);
    @(negedge clk);
    deny_valid = 1'b0;
  endtask

  function automatic logic [7:0] rec(input int f, input int w);
    return 8'(32'h20 + 16 * f + 4 * w);
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h04, d); check("R1 status", d, 0);
    rd(8'h00, d); check("R1 action", d, 0);
    rd(rec(0, 0), d); check("R1 addr lo", d, 0);
    rd(rec(3, 3), d); check("R1 id", d, 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_capture;
    logic [31:0] d;
    deny(1, 48'hAB_1234_5678, 1'b1, 1'b1, 1'b0, 8'h5A, 4'h3);
    rd(8'h04, d); check("R2 status", d, 32'h2);
    rd(rec(1, 0), d); check("R2 addr lo", d, 32'h1234_5678);
    rd(rec(1, 1), d); check("R2 addr hi", d, 32'hAB);
    rd(rec(1, 2), d); check("R3 ctl write/nonsec", d, 32'h0120_0000);
    rd(rec(1, 3), d); check("R4 id word", d, 32'h0300_005A);
    check("R9 no irq with action 0", 32'(irq), 0);
    deny(1, 48'h00_9999_0000, 1'b0, 1'b0, 1'b1, 8'h11, 4'h7);
    rd(8'h04, d); check("R5 overrun", d, 32'h202);
    rd(rec(1, 0), d); check("R5 record held", d, 32'h1234_5678);
    rd(rec(1, 3), d); check("R5 id held", d, 32'h0300_005A);
    wr(8'h08, 32'h2);
    rd(8'h04, d); check("R7 clear f1", d, 0);
  endtask

  task automatic t_unpriv_read;
    logic [31:0] d;
    deny(2, 48'hFFFF_0000_0040, 1'b0, 1'b0, 1'b1, 8'hC3, 4'hF);
    rd(rec(2, 2), d); check("R3 ctl read/secure/unpriv", d, 32'h0010_0000);
    rd(rec(2, 1), d); check("R2 addr hi f2", d, 32'hFFFF);
    rd(rec(2, 3), d); check("R4 id f2", d, 32'h0F00_00C3);
  endtask

  task automatic t_overlap_irq;
    logic [31:0] d;
    @(negedge clk); overlap = 4'b1000;
    @(negedge clk); overlap = '0;
    rd(8'h04, d); check("R6 overlap flag", d, 32'h0008_0004);
    wr(8'h00, 32'h1);
    check("R9 action bit0 only", 32'(irq), 0);
    wr(8'h00, 32'h2);
    check("R9 irq raised", 32'(irq), 1);
    rd(8'h00, d); check("R11 action readback", d, 32'h2);
    wr(8'h08, 32'h8);
    rd(8'h04, d); check("R7 selective clear", d, 32'h4);
    check("R9 irq still up", 32'(irq), 1);
    wr(8'h08, 32'h4);
    rd(8'h04, d); check("R7 clear f2", d, 0);
    check("R9 irq dropped", 32'(irq), 0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    deny(0, 48'h0000_AAAA_0000, 1'b0, 1'b0, 1'b0, 8'h01, 4'h0);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'h08; reg_wdata = 32'h1;
    set_deny(0, 48'h0000_BBBB_0000, 1'b1, 1'b0, 1'b0, 8'h02, 4'h1);
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; deny_valid = 1'b0;
    rd(8'h04, d); check("R8 flag kept, no overrun", d, 32'h1);
    rd(rec(0, 0), d); check("R8 record replaced", d, 32'hBBBB_0000);
    rd(rec(0, 2), d); check("R8 ctl replaced", d, 32'h0100_0000);
  endtask

  task automatic t_indep;
    logic [31:0] d;
    deny(3, 48'h0000_CCCC_0010, 1'b0, 1'b1, 1'b0, 8'h33, 4'h2);
    rd(rec(0, 0), d); check("R10 f0 untouched", d, 32'hBBBB_0000);
    rd(rec(3, 0), d); check("R10 f3 captured", d, 32'hCCCC_0010);
    rd(8'h04, d); check("R10 status", d, 32'h9);
  endtask

  task automatic t_map;
    logic [31:0] d;
    rd(8'h08, d); check("R11 clear reads zero", d, 0);
    rd(8'h0C, d); check("R11 unmapped", d, 0);
    rd(8'h60, d); check("R11 past records", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_capture();
    t_unpriv_read();
    t_overlap_irq();
    t_collide();
    t_indep();
    t_map();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule